// File: doc/BRIEF.md
# Tag-Waiting Reservation Station

This block holds a small pool of issued operations in front of a single functional unit. Each operation arrives with an opcode, the tag its result will carry, and two operands. An operand arrives either as a value or as the tag of the operation that will produce it. A waiting operand listens to the result broadcast bus. Every cycle, all waiting operands compare their tags with the broadcast tag at once. Each operand that matches takes the broadcast value.

An entry moves through three named states: `ENT_IDLE` (free), `ENT_WAIT` (at least one operand still pending) and `ENT_READY` (both operands hold values). The transitions are:
- *take*: `ENT_IDLE` to `ENT_WAIT` or `ENT_READY` on allocation.
- *wake*: `ENT_WAIT` to `ENT_READY` when the last pending operand is captured.
- *issue*: `ENT_READY` to `ENT_IDLE` when the entry is dispatched.
- *reissue*: `ENT_READY` straight into a newly allocated operation, in the same cycle the entry dispatches.

Among the ready entries, the one allocated earliest is dispatched. This order does not depend on which physical slot an entry sits in. A younger operation whose operands arrive first therefore leaves ahead of an older one that is still waiting. The functional unit accepts one operation per cycle, with no stall.

Top module: `rs_station`

## Requirements
- R1: After reset, every entry is free: `full` is 0 and `disp_valid` is 0.
- R2: An operation allocated with both operands marked ready is dispatched in the next cycle. It carries its opcode, its destination tag, and operand values A and B unchanged.
- R3: A pending operand captures `cdb_value` at a clock edge where `cdb_valid` is 1 and `cdb_tag` equals its tag. A broadcast with a different tag, or with `cdb_valid` at 0, leaves the operand pending.
- R4: One broadcast wakes every pending operand that holds its tag in the same cycle, across all entries and both operand positions.
- R5: An operand allocated as pending captures the broadcast that is on the bus in the allocation cycle, if the tags match. The entry is then ready in the next cycle.
- R6: When several entries are ready, the one allocated earliest dispatches. Any ready entry may dispatch while older entries are still waiting.
- R7: At most one entry dispatches per cycle. A dispatched entry leaves the pool, and a ready entry stays ready until it dispatches.
- R8: `full` is 1 when all DEPTH entries are occupied and none dispatches in that cycle. An allocation request is ignored while `full` is 1.
- R9: An entry that dispatches in a cycle can take a new allocation in that same cycle, and `full` is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Allocation request |
| alloc_op | input | OP_W | Opcode of the new operation |
| alloc_dst_tag | input | TAG_W | Tag the result will be broadcast with |
| alloc_a_rdy | input | 1 | Operand A holds a value (1) or waits on a tag (0) |
| alloc_a_tag | input | TAG_W | Producer tag of operand A |
| alloc_a_val | input | DATA_W | Value of operand A |
| alloc_b_rdy | input | 1 | Operand B holds a value (1) or waits on a tag (0) |
| alloc_b_tag | input | TAG_W | Producer tag of operand B |
| alloc_b_val | input | DATA_W | Value of operand B |
| cdb_valid | input | 1 | A result is on the broadcast bus |
| cdb_tag | input | TAG_W | Tag of the broadcast result |
| cdb_value | input | DATA_W | Broadcast result value |
| full | output | 1 | No entry can take an allocation this cycle |
| disp_valid | output | 1 | An operation is dispatched this cycle |
| disp_op | output | OP_W | Opcode of the dispatched operation |
| disp_dst_tag | output | TAG_W | Destination tag of the dispatched operation |
| disp_a | output | DATA_W | Operand A value |
| disp_b | output | DATA_W | Operand B value |

## Verification
The bench builds the station with DEPTH=3, TAG_W=4 and DATA_W=16. This is the size of an adder's pool. With only three entries and sixteen tags, the pool fills within a few cycles. Tags then collide often, so the following cases come up repeatedly:
- full-pool refusal;
- dispatch-and-refill in one cycle;
- one broadcast waking several entries.

A long pseudo-random run against an arithmetic model then covers most orderings of allocation, capture and dispatch over three slots.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [1:0] {
        ENT_IDLE  = 2'd0,
        ENT_WAIT  = 2'd1,
        ENT_READY = 2'd2
    } ent_state_e;

endpackage

// File: rtl/rs_operand_slot.sv
module rs_operand_slot #(
    parameter int TAG_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              hold,
    input  logic              in_rdy,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic [DATA_W-1:0] in_val,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_value,
    output logic              rdy_q,
    output logic [DATA_W-1:0] val_q,
    output logic              rdy_nxt
);

    logic [TAG_W-1:0]  tag_q, tag_nxt;
    logic [DATA_W-1:0] val_nxt;
    logic              hit_load, hit_wait;

    // snoop the bus both for a fresh operand and for one already waiting
    assign hit_load = cdb_valid && (cdb_tag == in_tag);
    assign hit_wait = hold && !rdy_q && cdb_valid && (cdb_tag == tag_q);

    always_comb begin
        rdy_nxt = rdy_q;
        val_nxt = val_q;
        tag_nxt = tag_q;
        if (load) begin
            tag_nxt = in_tag;
            if (in_rdy) begin
                rdy_nxt = 1'b1;
                val_nxt = in_val;
            end else if (hit_load) begin
                rdy_nxt = 1'b1;
                val_nxt = cdb_value;
            end else begin
                rdy_nxt = 1'b0;
                val_nxt = '0;
            end
        end else if (hit_wait) begin
            rdy_nxt = 1'b1;
            val_nxt = cdb_value;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdy_q <= 1'b0;
            val_q <= '0;
            tag_q <= '0;
        end else begin
            rdy_q <= rdy_nxt;
            val_q <= val_nxt;
            tag_q <= tag_nxt;
        end
    end

    AST_WAIT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !load && !rdy_q && cdb_valid && cdb_tag == tag_q)
        |=> (rdy_q && val_q == $past(cdb_value))); // R3

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !in_rdy && cdb_valid && cdb_tag == in_tag)
        |=> (rdy_q && val_q == $past(cdb_value))); // R5

    AST_MISS_KEEPS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !load && !rdy_q && !(cdb_valid && cdb_tag == tag_q))
        |=> !rdy_q); // R3

endmodule

// File: rtl/rs_entry.sv
module rs_entry
    import rs_pkg::*;
#(
    parameter int OP_W   = 4,
    parameter int TAG_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              issue,
    input  logic [OP_W-1:0]   in_op,
    input  logic [TAG_W-1:0]  in_dst,
    input  logic [1:0]        in_rdy,
    input  logic [1:0][TAG_W-1:0]  in_tag,
    input  logic [1:0][DATA_W-1:0] in_val,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_value,
    output logic              busy,
    output logic              ready,
    output logic [OP_W-1:0]   op_q,
    output logic [TAG_W-1:0]  dst_q,
    output logic [1:0][DATA_W-1:0] opnd_q
);

    localparam int NUM_OPND = 2;

    ent_state_e        state_q, state_nxt;
    logic [NUM_OPND-1:0] opnd_rdy, opnd_rdy_nxt;
    logic                both_nxt;

    assign busy  = (state_q != ENT_IDLE);
    assign ready = (state_q == ENT_READY);

    generate
        for (genvar k = 0; k < NUM_OPND; k++) begin : g_opnd
            rs_operand_slot #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .load      (take),
                .hold      (busy),
                .in_rdy    (in_rdy[k]),
                .in_tag    (in_tag[k]),
                .in_val    (in_val[k]),
                .cdb_valid (cdb_valid),
                .cdb_tag   (cdb_tag),
                .cdb_value (cdb_value),
                .rdy_q     (opnd_rdy[k]),
                .val_q     (opnd_q[k]),
                .rdy_nxt   (opnd_rdy_nxt[k])
            );
        end
    endgenerate

    assign both_nxt = &opnd_rdy_nxt;

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ENT_IDLE: begin
                if (take) state_nxt = both_nxt ? ENT_READY : ENT_WAIT;       // take
            end
            ENT_WAIT: begin
                if (both_nxt) state_nxt = ENT_READY;                         // wake
            end
            ENT_READY: begin
                if (issue && take) state_nxt = both_nxt ? ENT_READY : ENT_WAIT; // reissue
                else if (issue)    state_nxt = ENT_IDLE;                     // issue
            end
            default: state_nxt = ENT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ENT_IDLE;
        else        state_q <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= '0;
            dst_q <= '0;
        end else if (take) begin
            op_q  <= in_op;
            dst_q <= in_dst;
        end
    end

    AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENT_READY && !issue) |=> (state_q == ENT_READY)); // R7

    AST_ISSUE_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (state_q == ENT_READY)); // R7

    AST_TAKE_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (state_q == ENT_IDLE || issue)); // R8

    AST_READY_HAS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENT_READY) |-> (&opnd_rdy)); // R2

endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] alloc_hot,
    input  logic [N-1:0] ready,
    output logic [N-1:0] grant
);

    // older[i][j] = 1 : entry i was allocated before entry j
    logic [N-1:0][N-1:0] older;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            older <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                for (int j = 0; j < N; j++) begin
                    if (i == j)            older[i][j] <= 1'b0;
                    else if (alloc_hot[i]) older[i][j] <= 1'b0;
                    else if (alloc_hot[j]) older[i][j] <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            logic blocked;
            blocked = 1'b0;
            for (int j = 0; j < N; j++) begin
                if (j != i && ready[j] && older[j][i]) blocked = 1'b1;
            end
            grant[i] = ready[i] && !blocked;
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R7

    AST_READY_GETS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (|ready) |-> (|grant)); // R6

    AST_ALLOC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc_hot)); // R8

endmodule

// File: rtl/rs_alloc_pick.sv
module rs_alloc_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] avail,
    output logic [N-1:0] pick
);

    always_comb begin
        logic found;
        found = 1'b0;
        pick  = '0;
        for (int i = 0; i < N; i++) begin
            if (avail[i] && !found) begin
                pick[i] = 1'b1;
                found   = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rs_station.sv
module rs_station #(
    parameter int DEPTH  = 4,
    parameter int OP_W   = 4,
    parameter int TAG_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [OP_W-1:0]   alloc_op,
    input  logic [TAG_W-1:0]  alloc_dst_tag,
    input  logic              alloc_a_rdy,
    input  logic [TAG_W-1:0]  alloc_a_tag,
    input  logic [DATA_W-1:0] alloc_a_val,
    input  logic              alloc_b_rdy,
    input  logic [TAG_W-1:0]  alloc_b_tag,
    input  logic [DATA_W-1:0] alloc_b_val,
    input  logic              cdb_valid,
    input  logic [TAG_W-1:0]  cdb_tag,
    input  logic [DATA_W-1:0] cdb_value,
    output logic              full,
    output logic              disp_valid,
    output logic [OP_W-1:0]   disp_op,
    output logic [TAG_W-1:0]  disp_dst_tag,
    output logic [DATA_W-1:0] disp_a,
    output logic [DATA_W-1:0] disp_b
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DEPTH-1:0] busy, ready, grant, avail, pick, take;
    logic             alloc_go;
    logic [DEPTH-1:0][OP_W-1:0]        ent_op;
    logic [DEPTH-1:0][TAG_W-1:0]       ent_dst;
    logic [DEPTH-1:0][1:0][DATA_W-1:0] ent_opnd;
    logic [1:0][TAG_W-1:0]             in_tag;
    logic [1:0][DATA_W-1:0]            in_val;
    logic [CNT_W-1:0]                  occupancy;

    assign in_tag = {alloc_b_tag, alloc_a_tag};
    assign in_val = {alloc_b_val, alloc_a_val};

    // a dispatching entry counts as free in its own cycle
    assign avail    = ~busy | grant;
    assign full     = ~|avail;
    assign alloc_go = alloc_valid && !full;
    assign take     = pick & {DEPTH{alloc_go}};

    rs_alloc_pick #(.N(DEPTH)) u_alloc_pick (
        .avail (avail),
        .pick  (pick)
    );

    rs_age_pick #(.N(DEPTH)) u_age_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_hot (take),
        .ready     (ready),
        .grant     (grant)
    );

    generate
        for (genvar e = 0; e < DEPTH; e++) begin : g_ent
            rs_entry #(.OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_entry (
                .clk       (clk),
                .rst_n     (rst_n),
                .take      (take[e]),
                .issue     (grant[e]),
                .in_op     (alloc_op),
                .in_dst    (alloc_dst_tag),
                .in_rdy    ({alloc_b_rdy, alloc_a_rdy}),
                .in_tag    (in_tag),
                .in_val    (in_val),
                .cdb_valid (cdb_valid),
                .cdb_tag   (cdb_tag),
                .cdb_value (cdb_value),
                .busy      (busy[e]),
                .ready     (ready[e]),
                .op_q      (ent_op[e]),
                .dst_q     (ent_dst[e]),
                .opnd_q    (ent_opnd[e])
            );
        end
    endgenerate

    assign disp_valid = |grant;

    always_comb begin
        disp_op      = '0;
        disp_dst_tag = '0;
        disp_a       = '0;
        disp_b       = '0;
        for (int e = 0; e < DEPTH; e++) begin
            if (grant[e]) begin
                disp_op      = disp_op | ent_op[e];
                disp_dst_tag = disp_dst_tag | ent_dst[e];
                disp_a       = disp_a | ent_opnd[e][0];
                disp_b       = disp_b | ent_opnd[e][1];
            end
        end
    end

    always_comb begin
        occupancy = '0;
        for (int e = 0; e < DEPTH; e++) occupancy = occupancy + CNT_W'(busy[e]);
    end

    AST_FULL_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> (&busy)); // R8

    AST_OCCUPANCY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ({1'b0, occupancy} <= {1'b0, $past(occupancy)} + 1'b1)); // R9

    AST_DISPATCH_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !alloc_valid) |=> ({1'b0, occupancy} < {1'b0, $past(occupancy)} + 1'b1)); // R7

endmodule

// File: tb/test_rs_station.sv
`timescale 1ns/1ps
module test_rs_station;

    localparam int D  = 3;
    localparam int OW = 4;
    localparam int TW = 4;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          alloc_valid = 0;
    logic [OW-1:0] alloc_op = 0;
    logic [TW-1:0] alloc_dst_tag = 0;
    logic          alloc_a_rdy = 0, alloc_b_rdy = 0;
    logic [TW-1:0] alloc_a_tag = 0, alloc_b_tag = 0;
    logic [DW-1:0] alloc_a_val = 0, alloc_b_val = 0;
    logic          cdb_valid = 0;
    logic [TW-1:0] cdb_tag = 0;
    logic [DW-1:0] cdb_value = 0;
    logic          full, disp_valid;
    logic [OW-1:0] disp_op;
    logic [TW-1:0] disp_dst_tag;
    logic [DW-1:0] disp_a, disp_b;

    rs_station #(.DEPTH(D), .OP_W(OW), .TAG_W(TW), .DATA_W(DW)) i_rs_station (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_op(alloc_op), .alloc_dst_tag(alloc_dst_tag),
        .alloc_a_rdy(alloc_a_rdy), .alloc_a_tag(alloc_a_tag), .alloc_a_val(alloc_a_val),
        .alloc_b_rdy(alloc_b_rdy), .alloc_b_tag(alloc_b_tag), .alloc_b_val(alloc_b_val),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
        .full(full), .disp_valid(disp_valid), .disp_op(disp_op),
        .disp_dst_tag(disp_dst_tag), .disp_a(disp_a), .disp_b(disp_b)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 0;
    string cur_req  = "R1";

    // arithmetic model of the pool
    bit          m_busy [D];
    bit          m_ar [D], m_br [D];
    logic [TW-1:0] m_at [D], m_bt [D], m_dst [D];
    logic [DW-1:0] m_av [D], m_bv [D];
    logic [OW-1:0] m_op [D];
    int          m_seq [D];
    int          seq_ctr = 0;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic idle();
        alloc_valid = 0; cdb_valid = 0;
    endtask

    task automatic put(input logic [OW-1:0] op, input logic [TW-1:0] dst,
                       input bit ar, input logic [TW-1:0] at, input logic [DW-1:0] av,
                       input bit br, input logic [TW-1:0] bt, input logic [DW-1:0] bv);
        alloc_valid = 1; alloc_op = op; alloc_dst_tag = dst;
        alloc_a_rdy = ar; alloc_a_tag = at; alloc_a_val = av;
        alloc_b_rdy = br; alloc_b_tag = bt; alloc_b_val = bv;
    endtask

    task automatic bcast(input logic [TW-1:0] t, input logic [DW-1:0] v);
        cdb_valid = 1; cdb_tag = t; cdb_value = v;
    endtask

    // compare outputs for the current cycle, then advance the model over the edge
    task automatic step();
        int  idx;
        int  best;
        bit  ev, ef, all_busy;
        #1;
        idx = -1; best = 0;
        for (int i = 0; i < D; i++)
            if (m_busy[i] && m_ar[i] && m_br[i] && (idx < 0 || m_seq[i] < best)) begin
                idx = i; best = m_seq[i];
            end
        ev = (idx >= 0);
        all_busy = 1;
        for (int i = 0; i < D; i++) if (!m_busy[i]) all_busy = 0;
        ef = all_busy && !ev;
        chk(ev ? cur_req : "R7", "disp_valid", 64'(disp_valid), 64'(ev));
        chk(ef ? "R8" : cur_req, "full", 64'(full), 64'(ef));
        if (ev)
            chk(cur_req, "dispatch", 64'({disp_op, disp_dst_tag, disp_a, disp_b}),
                64'({m_op[idx], m_dst[idx], m_av[idx], m_bv[idx]}));
        if (ev) m_busy[idx] = 0;
        for (int i = 0; i < D; i++) if (m_busy[i] && cdb_valid) begin
            if (!m_ar[i] && m_at[i] == cdb_tag) begin m_ar[i] = 1; m_av[i] = cdb_value; end
            if (!m_br[i] && m_bt[i] == cdb_tag) begin m_br[i] = 1; m_bv[i] = cdb_value; end
        end
        if (alloc_valid && !ef) begin
            int f;
            f = -1;
            for (int i = 0; i < D; i++) if (!m_busy[i] && f < 0) f = i;
            m_busy[f] = 1; m_op[f] = alloc_op; m_dst[f] = alloc_dst_tag;
            m_at[f] = alloc_a_tag; m_bt[f] = alloc_b_tag; m_seq[f] = seq_ctr++;
            m_ar[f] = alloc_a_rdy || (cdb_valid && cdb_tag == alloc_a_tag);
            m_av[f] = alloc_a_rdy ? alloc_a_val : (m_ar[f] ? cdb_value : '0);
            m_br[f] = alloc_b_rdy || (cdb_valid && cdb_tag == alloc_b_tag);
            m_bv[f] = alloc_b_rdy ? alloc_b_val : (m_br[f] ? cdb_value : '0);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            report();
        end
    end

    initial begin
        logic [31:0] lfsr;
        for (int i = 0; i < D; i++) m_busy[i] = 0;
        repeat (2) @(negedge clk);
        chk("R1", "full in reset", 64'(full), 64'd0);
        chk("R1", "disp_valid in reset", 64'(disp_valid), 64'd0);
        rst_n = 1;
        @(negedge clk);
        cur_req = "R1"; idle(); step(); step();

        // R2: operands ready at allocation
        cur_req = "R2";
        put(4'h3, 4'h9, 1, 0, 16'h1234, 1, 0, 16'hBEEF); step();
        idle(); step();
        put(4'hA, 4'h2, 1, 0, 16'h0001, 1, 0, 16'hFFFF); step();
        put(4'h5, 4'h4, 1, 0, 16'h7777, 1, 0, 16'h8888); step();
        idle(); step(); step();

        // R3: miss by tag, miss by valid, then hit
        cur_req = "R3";
        put(4'h1, 4'h6, 0, 4'h5, 0, 1, 0, 16'h00AA); step();
        idle(); bcast(4'h6, 16'hDEAD); step();
        idle(); cdb_tag = 4'h5; cdb_value = 16'hCAFE; step();
        bcast(4'h5, 16'h5A5A); step();
        idle(); step(); step();

        // R4: one broadcast wakes several entries and both operands
        cur_req = "R4";
        put(4'h2, 4'h1, 0, 4'h7, 0, 0, 4'h7, 0); step();
        put(4'h3, 4'h2, 0, 4'h7, 0, 1, 0, 16'h0102); step();
        put(4'h4, 4'h3, 1, 0, 16'h0304, 0, 4'h7, 0); step();
        idle(); bcast(4'h7, 16'h7070); step();
        idle(); step(); step(); step(); step();

        // R5: capture in the allocation cycle
        cur_req = "R5";
        put(4'h6, 4'h8, 0, 4'h9, 0, 0, 4'h9, 0); bcast(4'h9, 16'h9999); step();
        idle(); step(); step();
        put(4'h7, 4'hB, 0, 4'hC, 0, 1, 0, 16'h1111); bcast(4'hD, 16'h2222); step();
        idle(); bcast(4'hC, 16'h3333); step();
        idle(); step(); step();

        // R6: younger ready entry overtakes older waiting ones
        cur_req = "R6";
        put(4'h8, 4'h1, 0, 4'h1, 0, 1, 0, 16'hA0A0); step();
        put(4'h9, 4'h2, 0, 4'h2, 0, 1, 0, 16'hB0B0); step();
        put(4'hA, 4'h3, 1, 0, 16'hC0C0, 1, 0, 16'hC1C1); step();
        idle(); bcast(4'h2, 16'h0202); step();
        idle(); bcast(4'h1, 16'h0101); step();
        idle(); step(); step(); step();

        // R8: full pool ignores a request
        cur_req = "R8";
        put(4'h1, 4'h1, 0, 4'h1, 0, 1, 0, 1); step();
        put(4'h2, 4'h2, 0, 4'h2, 0, 1, 0, 2); step();
        put(4'h3, 4'h3, 0, 4'h3, 0, 1, 0, 3); step();
        put(4'hF, 4'hF, 1, 0, 16'hFFFF, 1, 0, 16'hFFFF); step(); step();
        // R9: refill in the dispatch cycle
        cur_req = "R9";
        idle(); bcast(4'h2, 16'h2020); step();
        put(4'hE, 4'hE, 1, 0, 16'hEEEE, 1, 0, 16'hE0E0); step();
        idle(); bcast(4'h1, 16'h1010); step();
        bcast(4'h3, 16'h3030); step();
        idle(); step(); step(); step(); step();

        // R6: long pseudo-random mix against the model
        cur_req = "R6";
        lfsr = 32'h1ACE_B00C;
        for (int c = 0; c < 4000; c++) begin
            alloc_valid   = lfsr[0] | lfsr[1];
            alloc_op      = lfsr[7:4];
            alloc_dst_tag = lfsr[11:8];
            alloc_a_rdy   = lfsr[12] & lfsr[13];
            alloc_b_rdy   = lfsr[14] & lfsr[15];
            alloc_a_tag   = {1'b0, lfsr[18:16]};
            alloc_b_tag   = {1'b0, lfsr[21:19]};
            alloc_a_val   = lfsr[31:16];
            alloc_b_val   = lfsr[15:0];
            cdb_valid     = lfsr[22] | lfsr[23];
            cdb_tag       = {1'b0, lfsr[26:24]};
            cdb_value     = lfsr[27:12];
            step();
            for (int s = 0; s < 7; s++)
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        end
        idle();
        for (int c = 0; c < 4; c++) step();
        report();
    end

endmodule